// File: doc/BRIEF.md
# Lap-Stamped Descriptor Ring Producer

This block fills a circular ring of fixed-size descriptor entries in memory. An upstream agent offers a descriptor payload of seven 32-bit words over a valid/ready handshake. Once a payload is accepted, the block writes it out through a one-word-per-cycle memory write port into the next ring slot. It then writes an eighth word, the stamp word, which carries a ring tag and the current lap value. A slot index and a wrap counter are kept internally and are visible at the ports.

Because every entry ends with a lap value that changes on each pass through the ring, a consumer can tell fresh entries from stale ones by looking at the entry itself, without a head pointer. A small consumer-side checker in the same block holds the lap parity it expects next. It flags an entry as fresh when the entry's lap parity matches, and flips its expectation each time its own slot index wraps. Backpressure comes from a consumer read index: the producer always leaves one slot empty and will not write over the slot the consumer is about to read.

Top module: `ring_stamp_producer`

## Requirements
- R1: After reset, `prod_index` and `prod_lap` are 0, `mem_we` is 0, `chk_index` is 0 and `chk_fresh` reports a match for a lap parity of 1. `in_ready` is 1 whenever the ring has room.
- R2: A payload is accepted at the clock edge where `in_valid` and `in_ready` are both 1. On the 8 following cycles `mem_we` is 1. In cycle k (k = 0..7, where cycle 0 is the first cycle after the accepting edge) `mem_addr` = base + 32*slot + 4*k. For k = 0..6, `mem_wdata` is payload word k, taken from `in_words[32k+31:32k]`. The stamp word (k = 7) therefore comes last.
- R3: The stamp word holds the lap stamp in bits 31:28, the ring tag in bits 27:20, and zero in bits 19:0.
- R4: The lap stamp is (`prod_lap` + 1) mod 16. The first pass through the ring is therefore stamped 1, and the pass after the pass stamped 15 is stamped 0.
- R5: `prod_index` increments by one at the edge that ends an entry's stamp word, and returns from DEPTH-1 to 0. `prod_lap` increments (mod 16) at exactly that wrap.
- R6: When the slot after `prod_index` (mod DEPTH) equals `cons_rd_index`, `in_ready` is 0. An offered payload then causes no memory writes and no index change.
- R7: `in_ready` is 0 while an entry is being written. `cfg_base_addr` and `cfg_ring_tag` are sampled only while the block is idle, so changing them during a write does not affect that entry.
- R8: `chk_fresh` is 1 exactly when `chk_lap_lsb` equals the checker's expected parity. The expected parity is 1 after reset and flips each time `chk_index` wraps from DEPTH-1 to 0. `chk_index` advances by one on each clock edge where `chk_advance` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base_addr | input | ADDR_W | Byte address of ring slot 0 |
| cfg_ring_tag | input | 8 | Ring tag placed in each stamp word |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Payload can be accepted |
| in_words | input | 7*32 | Payload, word k in bits 32k+31:32k |
| cons_rd_index | input | IDX_W | Slot the consumer reads next |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | ADDR_W | Byte address of the word being written |
| mem_wdata | output | 32 | Word being written |
| prod_index | output | IDX_W | Slot the next entry goes to |
| prod_lap | output | 4 | Completed wraps of the producer, mod 16 |
| chk_lap_lsb | input | 1 | Lap parity of the entry the consumer examines |
| chk_advance | input | 1 | Consumer moves to its next slot |
| chk_fresh | output | 1 | Examined entry is fresh |
| chk_index | output | IDX_W | Consumer-side slot index |

## Verification
Word k of an entry is on the write port in the k-th cycle after the accepting edge. `prod_index` and `prod_lap` change at the edge that ends the stamp word, so they are first visible in the ninth cycle after acceptance, and `in_ready` returns in that same cycle. `chk_fresh` follows `chk_lap_lsb` within the same cycle, while `chk_index` and the expected parity move one edge after `chk_advance`. The bench drives inputs on the falling edge, finds the accepting edge by sampling `in_ready`, and then checks each word and each counter on the falling edge of the exact cycle in which it is due.

// File: rtl/rsp_pkg.sv
// Shared constants and the stamp-word builder for the lap-stamped ring producer.
// Assumes 32-bit words and an eight-word entry whose last word is the stamp.
package rsp_pkg;
    localparam int WORD_W        = 32;
    localparam int ENTRY_WORDS   = 8;
    localparam int PAYLOAD_WORDS = ENTRY_WORDS - 1;
    localparam int CNT_W         = $clog2(ENTRY_WORDS);
    localparam int LAP_W         = 4;
    localparam int TAG_W         = 8;
    localparam int LAP_LSB       = 28;
    localparam int TAG_LSB       = 20;

    // Builds the stamp word: lap in 31:28, tag in 27:20, zero below.
    function automatic logic [WORD_W-1:0] make_stamp(input logic [LAP_W-1:0] lap,
                                                     input logic [TAG_W-1:0] tag);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LAP_LSB +: LAP_W] = lap;
        w[TAG_LSB +: TAG_W] = tag;
        return w;
    endfunction
endpackage

// File: rtl/rsp_slot_tracker.sv
// Slot index with wrap counter. The index advances by one on 'advance' and
// returns to 0 after DEPTH-1; the wrap counter steps (mod 2**LAP_W) at that wrap.
// Assumes DEPTH >= 2.
module rsp_slot_tracker #(
    parameter int DEPTH = 4,
    parameter int LAP_W = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic [LAP_W-1:0] lap,
    output logic             at_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    // Flags the final slot of the ring.
    always_comb at_last = (idx == LAST_IDX);

    // Advances the index and counts wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            lap <= '0;
        end else if (advance) begin
            if (at_last) begin
                idx <= '0;
                lap <= lap + LAP_W'(1);
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX); // R5
    AST_LAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && at_last) |=> (idx == '0) && (lap == LAP_W'($past(lap) + LAP_W'(1)))); // R5
    AST_LAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(advance && at_last) |=> $stable(lap)); // R5
endmodule

// File: rtl/rsp_entry_writer.sv
// Accepts a seven-word payload and writes it, then the stamp word, to eight
// consecutive word addresses of one ring slot, one word per cycle.
// Assumes slot_idx and stamp_lap stay stable until entry_done, and that 'room'
// reflects ring occupancy. Configuration is latched only while idle.
module rsp_entry_writer
    import rsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               cfg_base_addr,
    input  logic [TAG_W-1:0]                cfg_ring_tag,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [PAYLOAD_WORDS*WORD_W-1:0] in_words,
    input  logic                            room,
    input  logic [IDX_W-1:0]                slot_idx,
    input  logic [LAP_W-1:0]                stamp_lap,
    output logic                            mem_we,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic [WORD_W-1:0]               mem_wdata,
    output logic                            entry_done
);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(ENTRY_WORDS - 1);

    logic                            busy;
    logic [CNT_W-1:0]                word_cnt;
    logic [PAYLOAD_WORDS*WORD_W-1:0] payload_q;
    logic [ADDR_W-1:0]               base_q;
    logic [TAG_W-1:0]                tag_q;
    logic                            accept;
    logic [WORD_W-1:0]               entry_word [ENTRY_WORDS];

    // Handshake: ready only when idle and the ring has a free slot.
    always_comb begin
        in_ready = !busy && room;
        accept   = in_valid && in_ready;
    end

    // Burst sequencer: busy for eight cycles after each accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            word_cnt <= '0;
        end else if (accept) begin
            busy     <= 1'b1;
            word_cnt <= '0;
        end else if (busy) begin
            if (word_cnt == LAST_WORD) begin
                busy <= 1'b0;
            end
            word_cnt <= word_cnt + CNT_W'(1);
        end
    end

    // Captures the payload at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            payload_q <= '0;
        end else if (accept) begin
            payload_q <= in_words;
        end
    end

    // Samples configuration only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            tag_q  <= '0;
        end else if (!busy) begin
            base_q <= cfg_base_addr;
            tag_q  <= cfg_ring_tag;
        end
    end

    // Lays out the entry: payload words, then the stamp word.
    for (genvar k = 0; k < PAYLOAD_WORDS; k++) begin : g_payload
        always_comb entry_word[k] = payload_q[k*WORD_W +: WORD_W];
    end
    always_comb entry_word[ENTRY_WORDS-1] = make_stamp(stamp_lap, tag_q);

    // Drives the word-write port.
    always_comb begin
        mem_we     = busy;
        entry_done = busy && (word_cnt == LAST_WORD);
        mem_addr   = base_q + ADDR_W'({slot_idx, word_cnt, 2'b00});
        mem_wdata  = entry_word[word_cnt];
    end

    AST_BURST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !entry_done) |=> mem_we && (mem_addr == $past(mem_addr) + ADDR_W'(4))); // R2
    AST_STAMP_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (mem_wdata[TAG_LSB-1:0] == '0)); // R3
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready); // R7
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !entry_done) |=> $stable(tag_q) && $stable(base_q)); // R7
endmodule

// File: rtl/rsp_fresh_checker.sv
// Consumer-side freshness check. Holds the lap parity expected on the next
// pass (1 after reset), flips it whenever its own slot index wraps, and flags
// an examined entry as fresh when its lap parity matches.
module rsp_fresh_checker #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lap_lsb,
    input  logic             advance,
    output logic             fresh,
    output logic [IDX_W-1:0] index
);
    logic wrap_parity;
    logic at_last;
    logic expect_bit;

    rsp_slot_tracker #(.DEPTH(DEPTH), .LAP_W(1)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .idx     (index),
        .lap     (wrap_parity),
        .at_last (at_last)
    );

    // Expected parity: the first pass is stamped odd.
    always_comb begin
        expect_bit = ~wrap_parity;
        fresh      = (lap_lsb == expect_bit);
    end

    AST_EXPECT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && at_last) |=> (expect_bit != $past(expect_bit))); // R8
endmodule

// File: rtl/ring_stamp_producer.sv
// Top of the lap-stamped descriptor ring producer. Ties the slot tracker,
// entry writer and consumer-side checker together and derives ring fullness
// from the consumer read index, leaving one slot empty.
// Assumes cons_rd_index < DEPTH and DEPTH >= 2.
module ring_stamp_producer
    import rsp_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               cfg_base_addr,
    input  logic [TAG_W-1:0]                cfg_ring_tag,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [PAYLOAD_WORDS*WORD_W-1:0] in_words,
    input  logic [IDX_W-1:0]                cons_rd_index,
    output logic                            mem_we,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic [WORD_W-1:0]               mem_wdata,
    output logic [IDX_W-1:0]                prod_index,
    output logic [LAP_W-1:0]                prod_lap,
    input  logic                            chk_lap_lsb,
    input  logic                            chk_advance,
    output logic                            chk_fresh,
    output logic [IDX_W-1:0]                chk_index
);
    logic             entry_done;
    logic             at_last;
    logic [IDX_W-1:0] next_index;
    logic             room;
    logic [LAP_W-1:0] stamp_lap;

    rsp_slot_tracker #(.DEPTH(DEPTH), .LAP_W(LAP_W)) u_prod_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (entry_done),
        .idx     (prod_index),
        .lap     (prod_lap),
        .at_last (at_last)
    );

    // Fullness and stamp: one slot stays empty; pass n is stamped n mod 16.
    always_comb begin
        next_index = at_last ? '0 : prod_index + IDX_W'(1);
        room       = (next_index != cons_rd_index);
        stamp_lap  = prod_lap + LAP_W'(1);
    end

    rsp_entry_writer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_writer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_base_addr (cfg_base_addr),
        .cfg_ring_tag  (cfg_ring_tag),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_words      (in_words),
        .room          (room),
        .slot_idx      (prod_index),
        .stamp_lap     (stamp_lap),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .entry_done    (entry_done)
    );

    rsp_fresh_checker #(.DEPTH(DEPTH)) u_checker (
        .clk     (clk),
        .rst_n   (rst_n),
        .lap_lsb (chk_lap_lsb),
        .advance (chk_advance),
        .fresh   (chk_fresh),
        .index   (chk_index)
    );

    AST_FULL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (next_index == cons_rd_index) |-> !in_ready); // R6
    AST_IDLE_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we && !in_ready) |=> $stable(prod_index) && !mem_we); // R6
endmodule

// File: tb/tb_ring_stamp_producer.sv
// Directed bench for ring_stamp_producer: one task per scenario.
module tb_ring_stamp_producer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = $clog2(DEPTH);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [ADDR_W-1:0]  cfg_base_addr = 32'h0004_0000;
    logic [7:0]         cfg_ring_tag = 8'hA5;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [7*32-1:0]    in_words = '0;
    logic [IDX_W-1:0]   cons_rd_index = IDX_W'(2);
    logic               mem_we;
    logic [ADDR_W-1:0]  mem_addr;
    logic [31:0]        mem_wdata;
    logic [IDX_W-1:0]   prod_index;
    logic [3:0]         prod_lap;
    logic               chk_lap_lsb = 1'b1;
    logic               chk_advance = 1'b0;
    logic               chk_fresh;
    logic [IDX_W-1:0]   chk_index;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    int  exp_idx = 0;
    int  exp_lap = 0;
    bit  saw_zero_stamp = 1'b0;

    ring_stamp_producer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_base_addr (cfg_base_addr),
        .cfg_ring_tag  (cfg_ring_tag),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_words      (in_words),
        .cons_rd_index (cons_rd_index),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .prod_index    (prod_index),
        .prod_lap      (prod_lap),
        .chk_lap_lsb   (chk_lap_lsb),
        .chk_advance   (chk_advance),
        .chk_fresh     (chk_fresh),
        .chk_index     (chk_index)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // R1: reset state.
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(prod_index == 0, "R1", "prod_index", 32'(prod_index), 0);
        check(prod_lap == 0, "R1", "prod_lap", 32'(prod_lap), 0);
        check(mem_we == 0, "R1", "mem_we", 32'(mem_we), 0);
        check(in_ready == 1, "R1", "in_ready", 32'(in_ready), 1);
        check(chk_index == 0, "R1", "chk_index", 32'(chk_index), 0);
        chk_lap_lsb = 1'b1;
        #1;
        check(chk_fresh == 1, "R1", "chk_fresh parity1", 32'(chk_fresh), 1);
        exp_idx = 0;
        exp_lap = 0;
    endtask

    // R2, R3, R4, R5, R7: push one entry and check each word in its cycle.
    task automatic t_push(input logic [31:0] seed, input bit disturb_cfg);
        logic [31:0] words [7];
        logic [31:0] base;
        logic [7:0]  tag;
        logic [3:0]  stamp;
        logic [31:0] exp_w;
        for (int k = 0; k < 7; k++) begin
            words[k] = seed ^ (32'h0101_0101 * 32'(k + 1));
            in_words[k*32 +: 32] = words[k];
        end
        cons_rd_index = IDX_W'((exp_idx + 2) % DEPTH);
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        base = cfg_base_addr;
        tag  = cfg_ring_tag;
        stamp = 4'(exp_lap + 1);
        @(negedge clk);
        in_valid = 1'b0;
        if (disturb_cfg) begin
            cfg_ring_tag  = ~tag;
            cfg_base_addr = base + 32'h100;
        end
        for (int k = 0; k < 8; k++) begin
            exp_w = (k < 7) ? words[k] : {stamp, tag, 20'h0};
            check(mem_we == 1, "R2", "mem_we in burst", 32'(mem_we), 1);
            check(in_ready == 0, "R7", "in_ready while busy", 32'(in_ready), 0);
            check(mem_addr == base + 32'(exp_idx * 32 + k * 4), disturb_cfg ? "R7" : "R2",
                  "mem_addr", mem_addr, base + 32'(exp_idx * 32 + k * 4));
            if (k == 7) begin
                check(mem_wdata == exp_w, disturb_cfg ? "R7" : "R3", "stamp word", mem_wdata, exp_w);
                check(mem_wdata[31:28] == stamp, "R4", "lap stamp", 32'(mem_wdata[31:28]), 32'(stamp));
                if (mem_wdata[31:28] == 4'd0) saw_zero_stamp = 1'b1;
            end else begin
                check(mem_wdata == exp_w, "R2", "payload word", mem_wdata, exp_w);
            end
            @(negedge clk);
        end
        if (disturb_cfg) begin
            cfg_ring_tag  = tag;
            cfg_base_addr = base;
        end
        if (exp_idx == DEPTH - 1) begin
            exp_idx = 0;
            exp_lap = (exp_lap + 1) % 16;
        end else begin
            exp_idx = exp_idx + 1;
        end
        check(mem_we == 0, "R2", "mem_we after burst", 32'(mem_we), 0);
        check(prod_index == IDX_W'(exp_idx), "R5", "prod_index", 32'(prod_index), 32'(exp_idx));
        check(prod_lap == 4'(exp_lap), "R5", "prod_lap", 32'(prod_lap), 32'(exp_lap));
    endtask

    // R6: full ring refuses payloads and writes nothing.
    task automatic t_full;
        cons_rd_index = IDX_W'((exp_idx + 1) % DEPTH);
        in_valid = 1'b1;
        #1;
        check(in_ready == 0, "R6", "in_ready when full", 32'(in_ready), 0);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check(mem_we == 0, "R6", "mem_we when full", 32'(mem_we), 0);
        end
        check(prod_index == IDX_W'(exp_idx), "R6", "prod_index held", 32'(prod_index), 32'(exp_idx));
        in_valid = 1'b0;
        cons_rd_index = IDX_W'((exp_idx + 2) % DEPTH);
        #1;
        check(in_ready == 1, "R6", "in_ready with room", 32'(in_ready), 1);
    endtask

    // R8: consumer checker parity tracking across a wrap.
    task automatic t_checker;
        chk_lap_lsb = 1'b1;
        #1;
        check(chk_fresh == 1, "R8", "odd stamp first pass", 32'(chk_fresh), 1);
        chk_lap_lsb = 1'b0;
        #1;
        check(chk_fresh == 0, "R8", "even stamp first pass", 32'(chk_fresh), 0);
        chk_advance = 1'b1;
        @(negedge clk);
        chk_advance = 1'b0;
        chk_lap_lsb = 1'b1;
        #1;
        check(chk_index == 1, "R8", "chk_index step", 32'(chk_index), 1);
        check(chk_fresh == 1, "R8", "parity kept mid pass", 32'(chk_fresh), 1);
        chk_advance = 1'b1;
        repeat (DEPTH - 1) @(negedge clk);
        chk_advance = 1'b0;
        #1;
        check(chk_index == 0, "R8", "chk_index wrap", 32'(chk_index), 0);
        check(chk_fresh == 0, "R8", "old parity stale", 32'(chk_fresh), 0);
        chk_lap_lsb = 1'b0;
        #1;
        check(chk_fresh == 1, "R8", "new parity fresh", 32'(chk_fresh), 1);
    endtask

    initial begin
        t_reset();
        t_push(32'hDEAD_0000, 1'b0);
        t_push(32'h1234_5678, 1'b0);
        t_full();
        t_push(32'hCAFE_0001, 1'b1);
        for (int n = 0; n < 68; n++) t_push(32'(n) * 32'h0003_0007, 1'b0);
        check(saw_zero_stamp == 1, "R4", "stamp wrapped to 0", 32'(saw_zero_stamp), 1);
        t_full();
        t_checker();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule